// File: doc/BRIEF.md
# Double-Buffered Catch-All CAN Receive Object

This block is the receive object that collects every frame the protocol engine hands over. It holds two buffers of up to eight data bytes each, plus four per-buffer flags: new-data, remote-pending, interrupt-pending and message-lost. At any moment exactly one buffer is assigned to the CPU. Incoming frames land in the other buffer, so two frames that arrive back to back are both kept while software is still reading the first one.

A buffer counts as allocated while its new-data or remote-pending flag is set. It counts as released once both are clear. Software releases the buffer it holds with a single control write. The CPU view then moves to the buffer holding the newer frame, and the released buffer becomes the landing place for the next frame. If both buffers are allocated when a frame arrives, the frame overwrites the buffer the CPU does not hold and marks it as having lost a message.

The frame-write side is a valid/ready stream. `fr_ready` is held high, because the object never back-pressures. A frame is accepted in every cycle where `fr_valid` and `fr_ready` are both high. When no free buffer exists, the object overwrites instead of stalling. The read side, the control write and the interrupt pins are plain signals.

Top module: `canrx_dualbuf`

## Requirements
- R1: After reset, all four flags of both buffers are 0, the CPU view points at buffer 0 (`rd_bufid`=0), and `irq` is low.
- R2: A buffer is allocated exactly when new-data OR remote-pending is 1. Storing a frame writes its data and length, sets new-data to 1, sets remote-pending to `fr_remote`, and sets message-lost to 1 if the buffer was allocated and to 0 if it was released.
- R3: A frame is stored in the buffer the CPU does not hold. If the CPU's buffer is allocated, the CPU view stays where it is. If the CPU's buffer is released, the view moves to the buffer that received the frame, effective from the next cycle.
- R4: When both buffers are allocated, a frame overwrites the non-CPU buffer and sets its message-lost flag. The CPU's buffer and the CPU view are left unchanged.
- R5: The control word 0x55DF clears new-data and remote-pending of the CPU's buffer and leaves its interrupt-pending and message-lost flags as they were. If the other buffer is allocated, the CPU view then moves to it.
- R6: The control word is a set of 2-bit codes: 01 clears a flag, 10 sets it, and 00 or 11 keeps it. The code positions are interrupt-pending [1:0], message-lost [3:2], new-data [9:8] and remote-pending [15:14]. A write acts only on the CPU's buffer, and all other bits are ignored.
- R7: Interrupt-pending is kept separately for each buffer. A stored frame sets it only when `rx_ie` is 1, and otherwise leaves it unchanged. `irq` equals the interrupt-pending flag of the buffer the CPU holds.
- R8: The transmit-enable code at [5:4] has no effect, because the object only receives.
- R9: When a frame and a control write arrive in the same cycle, the write is applied first. The frame then goes to the buffer that the CPU does not hold after that write.
- R10: `fr_ready` is 1 in every cycle after reset, and every cycle with `fr_valid` high stores one frame.
- R11: `rd_byte` is byte `rd_sel` of the CPU buffer's data, where byte k is bits [8k+7:8k]. `rd_len` is the CPU buffer's stored length. `rd_flags` is {message-lost, interrupt-pending, remote-pending, new-data} with new-data in bit 0. These outputs are combinational from the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fr_valid | input | 1 | Frame offered by the protocol engine |
| fr_ready | output | 1 | Frame accepted (always 1) |
| fr_data | input | 64 | Frame data bytes, byte k at [8k+7:8k] |
| fr_len | input | 4 | Frame data length code |
| fr_remote | input | 1 | Frame is a remote frame |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word (2-bit codes) |
| rx_ie | input | 1 | Receive interrupt enable |
| rd_sel | input | 3 | Byte index for the CPU read |
| rd_byte | output | 8 | Selected byte of the CPU buffer |
| rd_len | output | 4 | Length stored in the CPU buffer |
| rd_flags | output | 4 | Flags of the CPU buffer |
| rd_bufid | output | 1 | Index of the buffer the CPU holds |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench steers the object through every arrangement of released and allocated buffers. It sends frames while the CPU holds an empty buffer, a full buffer, and one of two full buffers. A design that stores into the CPU's buffer corrupts data under the reader. A design that forgets to move the CPU view leaves software looking at an empty buffer while a frame waits in the other. The bench also lands a release and a frame in the same cycle. A design that stores before releasing would overwrite the newer frame and flag a loss that did not happen. All 256 combinations of the four flag codes are swept, together with an ignored transmit-enable code and frames taken with interrupts disabled. This exposes a wrong bit position, a wrong code meaning, or an interrupt raised while it is masked.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

  localparam int CTL_W = 16;

  // Per-buffer flags, new-data in bit 0.
  typedef struct packed {
    logic ml;
    logic ip;
    logic rp;
    logic nd;
  } slot_flags_t;

  // Control codes extracted from the control word.
  typedef struct packed {
    logic [1:0] ml;
    logic [1:0] ip;
    logic [1:0] rp;
    logic [1:0] nd;
  } ctl_codes_t;

  function automatic logic code_upd(logic cur, logic [1:0] code);
    case (code)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  function automatic slot_flags_t ctl_apply(slot_flags_t f, ctl_codes_t c);
    slot_flags_t r;
    r.nd = code_upd(f.nd, c.nd);
    r.rp = code_upd(f.rp, c.rp);
    r.ip = code_upd(f.ip, c.ip);
    r.ml = code_upd(f.ml, c.ml);
    return r;
  endfunction

endpackage

// File: rtl/canrx_slot.sv
module canrx_slot
  import canrx_pkg::*;
#(
  parameter int NBYTES = 8,
  parameter int LEN_W  = 4,
  localparam int DATA_W = NBYTES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_hit,
  input  ctl_codes_t        ctl_codes,
  input  logic              store_en,
  input  logic              store_lost,
  input  logic              rx_ie,
  input  logic [DATA_W-1:0] st_data,
  input  logic [LEN_W-1:0]  st_len,
  input  logic              st_remote,
  output slot_flags_t       flags,
  output logic              alloc_w,
  output logic [DATA_W-1:0] data,
  output logic [LEN_W-1:0]  len
);

  slot_flags_t f_w;
  slot_flags_t f_n;

  // Control write first, then a store on top of it.
  always_comb begin
    f_w = ctl_hit ? ctl_apply(flags, ctl_codes) : flags;
    f_n = f_w;
    if (store_en) begin
      f_n.nd = 1'b1;
      f_n.rp = st_remote;
      f_n.ip = f_w.ip | rx_ie;
      f_n.ml = store_lost;
    end
  end

  assign alloc_w = f_w.nd | f_w.rp;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      data  <= '0;
      len   <= '0;
    end else begin
      flags <= f_n;
      if (store_en) begin
        data <= st_data;
        len  <= st_len;
      end
    end
  end

endmodule

// File: rtl/canrx_steer.sv
module canrx_steer (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] alloc_w,
  input  logic       fire,
  output logic       ptr,
  output logic [1:0] store_en,
  output logic       store_lost
);

  logic       oth;
  logic       mid;
  logic       tgt;
  logic       ptr_d;
  logic [1:0] n_alloc;

  always_comb begin
    oth = ~ptr;
    // View after this cycle's control write.
    mid = (!alloc_w[ptr] && alloc_w[oth]) ? oth : ptr;
    tgt = ~mid;
    store_en      = 2'b00;
    store_en[tgt] = fire;
    store_lost    = fire & alloc_w[tgt];
    n_alloc       = alloc_w;
    n_alloc[tgt]  = alloc_w[tgt] | fire;
    ptr_d = (!n_alloc[mid] && n_alloc[~mid]) ? ~mid : mid;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= 1'b0;
    else     ptr <= ptr_d;
  end

endmodule

// File: rtl/canrx_rdmux.sv
module canrx_rdmux
  import canrx_pkg::*;
#(
  parameter int NBYTES = 8,
  parameter int LEN_W  = 4,
  localparam int DATA_W = NBYTES * 8,
  localparam int SEL_W  = $clog2(NBYTES)
) (
  input  logic                   ptr,
  input  logic [SEL_W-1:0]       sel,
  input  logic [1:0][DATA_W-1:0] data,
  input  logic [1:0][LEN_W-1:0]  len,
  input  slot_flags_t [1:0]      flags,
  output logic [7:0]             rd_byte,
  output logic [LEN_W-1:0]       rd_len,
  output slot_flags_t            rd_flags
);

  logic [DATA_W-1:0] cur;

  always_comb begin
    cur     = data[ptr];
    rd_len  = len[ptr];
    rd_flags = flags[ptr];
    rd_byte = '0;
    for (int k = 0; k < NBYTES; k++) begin
      if (sel == SEL_W'(k)) rd_byte = cur[8*k +: 8];
    end
  end

endmodule

// File: rtl/canrx_dualbuf.sv
module canrx_dualbuf
  import canrx_pkg::*;
#(
  parameter int NBYTES = 8,
  parameter int LEN_W  = 4,
  localparam int DATA_W = NBYTES * 8,
  localparam int SEL_W  = $clog2(NBYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fr_valid,
  output logic              fr_ready,
  input  logic [DATA_W-1:0] fr_data,
  input  logic [LEN_W-1:0]  fr_len,
  input  logic              fr_remote,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  input  logic              rx_ie,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [7:0]        rd_byte,
  output logic [LEN_W-1:0]  rd_len,
  output logic [3:0]        rd_flags,
  output logic              rd_bufid,
  output logic              irq
);

  ctl_codes_t             codes;
  logic                   unused_ctl;
  logic                   fire;
  logic                   ptr_q;
  logic [1:0]             store_en;
  logic                   store_lost;
  logic [1:0]             alloc_w;
  slot_flags_t [1:0]      flg;
  logic [1:0][DATA_W-1:0] dat;
  logic [1:0][LEN_W-1:0]  lens;
  slot_flags_t            cur_flags;
  logic [1:0]             nd_v, rp_v, ip_v, ml_v;

  assign fr_ready = 1'b1;
  assign fire     = fr_valid & fr_ready;

  assign codes.ip = ctl_wdata[1:0];
  assign codes.ml = ctl_wdata[3:2];
  assign codes.nd = ctl_wdata[9:8];
  assign codes.rp = ctl_wdata[15:14];
  // Transmit-enable code [5:4] and the rest are ignored.
  assign unused_ctl = ^{ctl_wdata[7:4], ctl_wdata[13:10]};

  for (genvar g = 0; g < 2; g++) begin : g_slot
    canrx_slot #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_slot (
      .clk        (clk),
      .rst        (rst),
      .ctl_hit    (ctl_we && (ptr_q == 1'(g))),
      .ctl_codes  (codes),
      .store_en   (store_en[g]),
      .store_lost (store_lost),
      .rx_ie      (rx_ie),
      .st_data    (fr_data),
      .st_len     (fr_len),
      .st_remote  (fr_remote),
      .flags      (flg[g]),
      .alloc_w    (alloc_w[g]),
      .data       (dat[g]),
      .len        (lens[g])
    );
    assign nd_v[g] = flg[g].nd;
    assign rp_v[g] = flg[g].rp;
    assign ip_v[g] = flg[g].ip;
    assign ml_v[g] = flg[g].ml;
  end

  canrx_steer u_steer (
    .clk        (clk),
    .rst        (rst),
    .alloc_w    (alloc_w),
    .fire       (fire),
    .ptr        (ptr_q),
    .store_en   (store_en),
    .store_lost (store_lost)
  );

  canrx_rdmux #(.NBYTES(NBYTES), .LEN_W(LEN_W)) u_rdmux (
    .ptr      (ptr_q),
    .sel      (rd_sel),
    .data     (dat),
    .len      (lens),
    .flags    (flg),
    .rd_byte  (rd_byte),
    .rd_len   (rd_len),
    .rd_flags (cur_flags)
  );

  assign rd_flags = cur_flags;
  assign rd_bufid = ptr_q;
  assign irq      = cur_flags.ip;

endmodule

// File: rtl/canrx_dualbuf_chk.sv
module canrx_dualbuf_chk (
  input logic       clk,
  input logic       rst,
  input logic       fire,
  input logic       ctl_we,
  input logic       rx_ie,
  input logic       ptr,
  input logic [1:0] nd,
  input logic [1:0] rp,
  input logic [1:0] ip,
  input logic [1:0] ml
);

  logic [1:0] alloc;
  assign alloc = nd | rp;

  // R1: reset clears every flag and points the view at buffer 0
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (nd == 2'b00 && rp == 2'b00 && ip == 2'b00 && ml == 2'b00 && !ptr));

  // R3: the CPU never sits on a released buffer while the other holds a frame
  assert_view_on_alloc_R3: assert property (@(posedge clk) disable iff (rst)
    alloc[~ptr] |-> alloc[ptr]);

  // R3: with an allocated buffer and no write, the view does not move
  assert_view_stays_R3: assert property (@(posedge clk) disable iff (rst)
    (alloc[ptr] && !ctl_we) |=> $stable(ptr));

  // R2: after a store the CPU's buffer is allocated
  assert_store_alloc_R2: assert property (@(posedge clk) disable iff (rst)
    fire |=> alloc[ptr]);

  // R4: overwrite while both buffers are full marks a lost message
  assert_overwrite_lost_R4: assert property (@(posedge clk) disable iff (rst)
    (fire && alloc == 2'b11 && !ctl_we) |=> (ptr == $past(ptr)) && ml[~$past(ptr)]);

  // R7: with receive interrupts off, no pending bit appears
  assert_no_ie_no_pend_R7: assert property (@(posedge clk) disable iff (rst)
    (!rx_ie && !ctl_we && ip == 2'b00) |=> ip == 2'b00);

endmodule

bind canrx_dualbuf canrx_dualbuf_chk u_chk (
  .clk    (clk),
  .rst    (rst),
  .fire   (fr_valid & fr_ready),
  .ctl_we (ctl_we),
  .rx_ie  (rx_ie),
  .ptr    (ptr_q),
  .nd     (nd_v),
  .rp     (rp_v),
  .ip     (ip_v),
  .ml     (ml_v)
);

// File: tb/canrx_dualbuf_test.sv
`timescale 1ns/1ps
module canrx_dualbuf_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        fr_valid;
  logic        fr_ready;
  logic [63:0] fr_data;
  logic [3:0]  fr_len;
  logic        fr_remote;
  logic        ctl_we;
  logic [15:0] ctl_wdata;
  logic        rx_ie;
  logic [2:0]  rd_sel;
  logic [7:0]  rd_byte;
  logic [3:0]  rd_len;
  logic [3:0]  rd_flags;
  logic        rd_bufid;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;

  // Reference state built from the requirements
  logic [1:0]  m_nd, m_rp, m_ip, m_ml;
  logic        m_ptr;
  logic [63:0] m_data [2];
  logic [3:0]  m_len  [2];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #10 clk = ~clk;

  canrx_dualbuf uut (
    .clk(clk), .rst(rst), .fr_valid(fr_valid), .fr_ready(fr_ready),
    .fr_data(fr_data), .fr_len(fr_len), .fr_remote(fr_remote),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .rx_ie(rx_ie),
    .rd_sel(rd_sel), .rd_byte(rd_byte), .rd_len(rd_len),
    .rd_flags(rd_flags), .rd_bufid(rd_bufid), .irq(irq)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
    summary();
  end

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic upd(logic cur, logic [1:0] code);
    if (code == 2'b01) return 1'b0;
    if (code == 2'b10) return 1'b1;
    return cur;
  endfunction

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  task automatic check_out(string tag);
    logic p;
    p = m_ptr;
    cmp(tag, "bufid", 64'(rd_bufid), 64'(p));
    cmp(tag, "flags", 64'(rd_flags), 64'({m_ml[p], m_ip[p], m_rp[p], m_nd[p]}));
    cmp(tag, "irq",   64'(irq),      64'(m_ip[p]));
    cmp(tag, "len",   64'(rd_len),   64'(m_len[p]));
    cmp(tag, "byte",  64'(rd_byte),  64'(m_data[p][8*rd_sel +: 8]));
  endtask

  task automatic step(input logic fv, input logic [63:0] d, input logic [3:0] l,
                      input logic rem, input logic we, input logic [15:0] wd,
                      input logic ie, input logic [2:0] sel, input string tag);
    logic p, o, mid, t, lost;
    logic [1:0] al;
    @(negedge clk);
    fr_valid = fv; fr_data = d; fr_len = l; fr_remote = rem;
    ctl_we = we; ctl_wdata = wd; rx_ie = ie; rd_sel = sel;
    @(posedge clk);
    #1;
    fr_valid = 1'b0; ctl_we = 1'b0;
    p = m_ptr; o = ~p;
    if (we) begin
      m_ip[p] = upd(m_ip[p], wd[1:0]);
      m_ml[p] = upd(m_ml[p], wd[3:2]);
      m_nd[p] = upd(m_nd[p], wd[9:8]);
      m_rp[p] = upd(m_rp[p], wd[15:14]);
    end
    al  = m_nd | m_rp;
    mid = (!al[p] && al[o]) ? o : p;
    t   = ~mid;
    if (fv) begin
      lost = al[t];
      m_data[t] = d; m_len[t] = l;
      m_nd[t] = 1'b1; m_rp[t] = rem;
      m_ip[t] = m_ip[t] | ie;
      m_ml[t] = lost;
    end
    al = m_nd | m_rp;
    m_ptr = (!al[mid] && al[~mid]) ? ~mid : mid;
    check_out(tag);
  endtask

  task automatic idle(input logic [2:0] sel, input string tag);
    step(1'b0, 64'h0, 4'h0, 1'b0, 1'b0, 16'hFFFF, 1'b1, sel, tag);
  endtask

  task automatic frame(input logic [63:0] d, input logic [3:0] l, input logic rem,
                       input logic ie, input string tag);
    step(1'b1, d, l, rem, 1'b0, 16'hFFFF, ie, 3'(rnd()), tag);
  endtask

  task automatic wr(input logic [15:0] wd, input string tag);
    step(1'b0, 64'h0, 4'h0, 1'b0, 1'b1, wd, 1'b1, 3'(rnd()), tag);
  endtask

  initial begin
    rst = 1'b1; fr_valid = 1'b0; fr_data = '0; fr_len = '0; fr_remote = 1'b0;
    ctl_we = 1'b0; ctl_wdata = '0; rx_ie = 1'b0; rd_sel = '0;
    m_nd = '0; m_rp = '0; m_ip = '0; m_ml = '0; m_ptr = 1'b0;
    for (int i = 0; i < 2; i++) begin m_data[i] = '0; m_len[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset state
    check_out("R1");
    // R10: the stream side never back-pressures
    cmp("R10", "fr_ready", 64'(fr_ready), 64'h1);

    // R3: first frame lands in buffer 1, view follows since buffer 0 is empty
    frame(64'h8877_6655_4433_2211, 4'd8, 1'b0, 1'b1, "R3");
    // R3: second frame goes to buffer 0, view stays on buffer 1
    frame(64'h0102_0304_0506_0708, 4'd5, 1'b0, 1'b1, "R3");
    // R11: walk all byte positions of the CPU buffer
    for (int s = 0; s < 8; s++) idle(3'(s), "R11");
    // R4: both full, third frame overwrites buffer 0 and sets message-lost
    frame(64'hCAFE_F00D_DEAD_BEEF, 4'd7, 1'b0, 1'b1, "R4");
    // R5: release moves the view to the newer frame
    wr(16'h55DF, "R5");
    // R7: clear pending in the newly viewed buffer
    wr(16'hFFFD, "R7");
    // R8: transmit-enable code set and cleared has no effect
    wr(16'hFFEF, "R8");
    wr(16'hFFDF, "R8");
    // R6: set then clear message-lost through its own code
    wr(16'hFFFB, "R6");
    wr(16'hFFF7, "R6");
    // R2: a remote frame arrives with interrupts off
    frame(64'h1111_2222_3333_4444, 4'd0, 1'b1, 1'b0, "R2");
    // R7: the pending bit was not raised by a frame taken with interrupts off
    idle(3'd0, "R7");
    // R9: release and frame in the same cycle
    step(1'b1, 64'h5A5A_A5A5_0F0F_F0F0, 4'd3, 1'b0, 1'b1, 16'h55DF, 1'b1, 3'd2, "R9");
    idle(3'd2, "R9");
    // R5: release the remaining buffers one by one
    wr(16'h55DF, "R5");
    wr(16'h55DF, "R5");

    // R6: sweep all code combinations of the four flags, with frames interleaved
    for (int k = 0; k < 256; k++) begin
      logic [15:0] w;
      w = 16'hFFFF;
      w[1:0] = k[1:0]; w[3:2] = k[3:2]; w[9:8] = k[5:4]; w[15:14] = k[7:6];
      step(k[0] ^ k[3], {rnd(), rnd()}, 4'(rnd()), k[2], 1'b1, w, k[1] | k[6],
           3'(k), "R6");
    end

    // R2: mixed traffic sweep over all combinations of events
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      logic [15:0] w;
      r = rnd();
      case (r[9:8])
        2'd0: w = 16'h55DF;
        2'd1: w = 16'hFFFD;
        2'd2: w = 16'(rnd());
        default: w = 16'hFFFF;
      endcase
      step(r[0], {rnd(), rnd()}, r[7:4], r[1], r[2], w, r[3], r[12:10], "R2");
    end

    summary();
  end

endmodule